// File: doc/BRIEF.md
# Bus Access Address Error Checker

This block sits between a 32-bit processor pipeline and its memory port. It examines every access that the pipeline presents: an instruction fetch or a data access, its size, its direction, and the privilege mode in force. Two kinds of fault are detected. The first is a misaligned access. The second is an access made in user mode to the upper half of the logical space.

When an access is legal, the block passes its valid strobe on to memory unchanged. When an access is illegal, the strobe is withheld in the same cycle, so the access has no side effect and can be executed again later. On the next clock edge the block raises a one-cycle exception request. Alongside the request it holds the exception code, the faulting logical address and the address at which execution must resume.

Exception dispatch, state saving and the handler are left to the surrounding core.

Top module: `addr_err_checker`

## Requirements
- R1: An instruction fetch (`acc_fetch`=1) with address bit 0 set is an error, whatever `acc_size` holds.
- R2: A data access of word size (`acc_size`=1) with address bit 0 set is an error.
- R3: A data access of longword size (`acc_size`=2 or 3) whose address bits [1:0] are not 00 is an error.
- R4: Any access with `user_mode`=1 and address bit 31 set is an error, regardless of alignment or size.
- R5: A byte data access (`acc_size`=0) is never an alignment error.
- R6: The exception code is 0x100 for a faulting data write. It is 0x0E0 for a faulting data read or any faulting fetch, because a fetch counts as a read even if `acc_write` is 1.
- R7: On an error, `fault_addr` takes the full 32-bit access address.
- R8: On a faulting fetch, `ret_pc` takes the fetch address.
- R9: On a faulting data access, `ret_pc` takes `instr_pc`, or `branch_pc` when `in_dslot`=1.
- R10: `mem_valid` equals `acc_valid` in the same cycle when the access is legal, and is 0 when it is an error.
- R11: `exc_req` is 1 for exactly the cycle after a clock edge that sampled a valid faulting access. `exc_code`, `fault_addr` and `ret_pc` change only on such an edge.
- R12: With `rst_n` low, `exc_req`, `exc_code`, `fault_addr` and `ret_pc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_addr | input | 32 | Logical address of the access |
| acc_size | input | 2 | 0 byte, 1 word, 2 or 3 longword |
| acc_write | input | 1 | 1 for a write |
| acc_fetch | input | 1 | 1 for an instruction fetch |
| user_mode | input | 1 | 1 when running unprivileged |
| instr_pc | input | 32 | Address of the issuing instruction |
| in_dslot | input | 1 | Issuing instruction sits in a delay slot |
| branch_pc | input | 32 | Address of the delayed branch owning the slot |
| mem_valid | output | 1 | Access strobe forwarded to memory |
| exc_req | output | 1 | One-cycle exception request |
| exc_code | output | 12 | Exception code |
| fault_addr | output | 32 | Faulting logical address |
| ret_pc | output | 32 | Resume address |

## Verification
The bench sweeps every combination of the two low address bits, the access size, the direction, fetch versus data, the mode, the top address bit and the delay-slot flag. It also covers idle cycles and reserved-size accesses.

Each case targets a specific way the design could go wrong:
- Applying the size rules to fetches would miss odd word fetches, or fault on legal fetches.
- Checking longwords with bit 0 alone would let offset 2 through.
- Reporting a fetch as a write would give code 0x100.
- Ignoring the delay-slot flag would save the wrong resume address.
- Letting the holding registers follow the inputs would corrupt the reported values during the idle cycles that follow a fault.

// File: rtl/addr_err_pkg.sv
package addr_err_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam int unsigned ADDR_W_DEF = 32;
  localparam int unsigned CODE_W_DEF = 12;
endpackage

// File: rtl/aec_align_chk.sv
module aec_align_chk
  import addr_err_pkg::*;
(
  input  logic       fetch,
  input  logic [1:0] size,
  input  logic [1:0] low_bits,
  output logic       misaligned
);
  always_comb begin
    if (fetch) begin
      misaligned = low_bits[0];
    end else begin
      case (acc_size_e'(size))
        SZ_BYTE: misaligned = 1'b0;
        SZ_WORD: misaligned = low_bits[0];
        default: misaligned = |low_bits;
      endcase
    end
  end
endmodule

// File: rtl/aec_space_chk.sv
module aec_space_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              user,
  input  logic [ADDR_W-1:0] addr,
  output logic              violation
);
  localparam int unsigned TOP = ADDR_W - 1;

  always_comb begin
    violation = user & addr[TOP];
  end
endmodule

// File: rtl/aec_capture.sv
module aec_capture #(
  parameter int unsigned    ADDR_W  = 32,
  parameter int unsigned    CODE_W  = 12,
  parameter logic [CODE_W-1:0] CODE_RD = 12'h0E0,
  parameter logic [CODE_W-1:0] CODE_WR = 12'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] resume_pc,
  output logic              req_q,
  output logic [CODE_W-1:0] code_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] pc_q
);
  logic [CODE_W-1:0] code_d;
  logic              hold_en;

  always_comb begin
    hold_en = err;
    code_d  = is_write ? CODE_WR : CODE_RD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      addr_q <= '0;
      pc_q   <= '0;
    end else if (hold_en) begin
      code_q <= code_d;
      addr_q <= addr;
      pc_q   <= resume_pc;
    end
  end
endmodule

// File: rtl/addr_err_checker.sv
module addr_err_checker
  import addr_err_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned CODE_W = CODE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic              acc_write,
  input  logic              acc_fetch,
  input  logic              user_mode,
  input  logic [ADDR_W-1:0] instr_pc,
  input  logic              in_dslot,
  input  logic [ADDR_W-1:0] branch_pc,
  output logic              mem_valid,
  output logic              exc_req,
  output logic [CODE_W-1:0] exc_code,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [ADDR_W-1:0] ret_pc
);
  logic              mis;
  logic              priv_viol;
  logic              err;
  logic              eff_write;
  logic [ADDR_W-1:0] resume_pc;

  aec_align_chk u_align (
    .fetch      (acc_fetch),
    .size       (acc_size),
    .low_bits   (acc_addr[1:0]),
    .misaligned (mis)
  );

  aec_space_chk #(.ADDR_W(ADDR_W)) u_space (
    .user      (user_mode),
    .addr      (acc_addr),
    .violation (priv_viol)
  );

  always_comb begin
    err       = acc_valid & (mis | priv_viol);
    mem_valid = acc_valid & ~err;
    eff_write = acc_write & ~acc_fetch;
    if (acc_fetch)     resume_pc = acc_addr;
    else if (in_dslot) resume_pc = branch_pc;
    else               resume_pc = instr_pc;
  end

  aec_capture #(
    .ADDR_W  (ADDR_W),
    .CODE_W  (CODE_W),
    .CODE_RD (CODE_W'(12'h0E0)),
    .CODE_WR (CODE_W'(12'h100))
  ) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .err       (err),
    .is_write  (eff_write),
    .addr      (acc_addr),
    .resume_pc (resume_pc),
    .req_q     (exc_req),
    .code_q    (exc_code),
    .addr_q    (fault_addr),
    .pc_q      (ret_pc)
  );
endmodule

// File: rtl/addr_err_checker_sva.sv
module addr_err_checker_sva #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [1:0]        acc_size,
  input logic              acc_fetch,
  input logic              user_mode,
  input logic              mem_valid,
  input logic              exc_req,
  input logic [CODE_W-1:0] exc_code,
  input logic [ADDR_W-1:0] fault_addr,
  input logic [ADDR_W-1:0] ret_pc
);
  // R1
  odd_fetch_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_fetch && acc_addr[0]) |-> !mem_valid);
  // R2
  odd_word_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_fetch && acc_size == 2'd1 && acc_addr[0]) |-> !mem_valid);
  // R3
  long_misalign_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_fetch && acc_size[1] && acc_addr[1:0] != 2'b00) |-> !mem_valid);
  // R4
  user_high_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && user_mode && acc_addr[ADDR_W-1]) |-> !mem_valid);
  // R5
  byte_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_fetch && acc_size == 2'd0 && !(user_mode && acc_addr[ADDR_W-1])) |-> mem_valid);
  // R10
  no_spurious_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> acc_valid);
  // R11
  req_follows_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !mem_valid) |=> exc_req);
  // R11
  req_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> $past(acc_valid && !mem_valid));
  // R7
  fault_addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !mem_valid) |=> (fault_addr == $past(acc_addr)));
  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |-> ($stable(fault_addr) && $stable(ret_pc) && $stable(exc_code)));
endmodule

bind addr_err_checker addr_err_checker_sva #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_addr   (acc_addr),
  .acc_size   (acc_size),
  .acc_fetch  (acc_fetch),
  .user_mode  (user_mode),
  .mem_valid  (mem_valid),
  .exc_req    (exc_req),
  .exc_code   (exc_code),
  .fault_addr (fault_addr),
  .ret_pc     (ret_pc)
);

// File: tb/addr_err_checker_tb_top.sv
module addr_err_checker_tb_top;
  logic        clk;
  logic        rst_n;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic [1:0]  acc_size;
  logic        acc_write;
  logic        acc_fetch;
  logic        user_mode;
  logic [31:0] instr_pc;
  logic        in_dslot;
  logic [31:0] branch_pc;
  logic        mem_valid;
  logic        exc_req;
  logic [11:0] exc_code;
  logic [31:0] fault_addr;
  logic [31:0] ret_pc;

  int checks;
  int errors;
  logic finished;

  logic [11:0] m_code;
  logic [31:0] m_addr;
  logic [31:0] m_pc;

  addr_err_checker dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .acc_size   (acc_size),
    .acc_write  (acc_write),
    .acc_fetch  (acc_fetch),
    .user_mode  (user_mode),
    .instr_pc   (instr_pc),
    .in_dslot   (in_dslot),
    .branch_pc  (branch_pc),
    .mem_valid  (mem_valid),
    .exc_req    (exc_req),
    .exc_code   (exc_code),
    .fault_addr (fault_addr),
    .ret_pc     (ret_pc)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access: drive after negedge, check strobe, then registered outputs.
  task automatic access(input logic v, input logic [31:0] a, input logic [1:0] sz,
                        input logic wr, input logic fe, input logic us,
                        input logic [31:0] ipc, input logic ds, input logic [31:0] bpc);
    logic mis, bad;
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_size = sz; acc_write = wr; acc_fetch = fe;
    user_mode = us; instr_pc = ipc; in_dslot = ds; branch_pc = bpc;
    if (fe)            mis = a[0];
    else if (sz == 2'd0) mis = 1'b0;
    else if (sz == 2'd1) mis = a[0];
    else               mis = (a[1:0] != 2'b00);
    bad = v && (mis || (us && a[31]));
    #1;
    if (fe) chk("R1/R10 mem_valid", {31'd0, mem_valid}, {31'd0, v && !bad});
    else if (sz == 2'd0) chk("R5/R10 mem_valid", {31'd0, mem_valid}, {31'd0, v && !bad});
    else if (sz == 2'd1) chk("R2/R10 mem_valid", {31'd0, mem_valid}, {31'd0, v && !bad});
    else chk("R3/R4/R10 mem_valid", {31'd0, mem_valid}, {31'd0, v && !bad});
    if (bad) begin
      m_code = (wr && !fe) ? 12'h100 : 12'h0E0;
      m_addr = a;
      m_pc   = fe ? a : (ds ? bpc : ipc);
    end
    @(negedge clk);
    chk("R11 exc_req", {31'd0, exc_req}, {31'd0, bad});
    chk("R6 exc_code", {20'd0, exc_code}, {20'd0, m_code});
    chk("R7 fault_addr", fault_addr, m_addr);
    if (fe) chk("R8 ret_pc", ret_pc, m_pc);
    else    chk("R9 ret_pc", ret_pc, m_pc);
  endtask

  initial begin
    checks = 0; errors = 0; finished = 1'b0;
    m_code = '0; m_addr = '0; m_pc = '0;
    rst_n = 1'b0;
    acc_valid = 0; acc_addr = 0; acc_size = 0; acc_write = 0; acc_fetch = 0;
    user_mode = 0; instr_pc = 0; in_dslot = 0; branch_pc = 0;
    repeat (2) @(negedge clk);
    // R12 reset state
    chk("R12 exc_req", {31'd0, exc_req}, 32'd0);
    chk("R12 exc_code", {20'd0, exc_code}, 32'd0);
    chk("R12 fault_addr", fault_addr, 32'd0);
    chk("R12 ret_pc", ret_pc, 32'd0);
    rst_n = 1'b1;

    for (int lo = 0; lo < 4; lo++)
      for (int sz = 0; sz < 4; sz++)
        for (int wr = 0; wr < 2; wr++)
          for (int fe = 0; fe < 2; fe++)
            for (int us = 0; us < 2; us++)
              for (int hi = 0; hi < 2; hi++)
                for (int ds = 0; ds < 2; ds++) begin
                  logic [31:0] a;
                  a = {hi[0], 7'h12, 22'h0ABC0 + 22'(lo * 64 + sz * 8), lo[1:0]};
                  access(1'b1, a, sz[1:0], wr[0], fe[0], us[0],
                         32'h0000_4000 + 32'(sz * 16 + lo * 2),
                         ds[0], 32'h0000_3F00 + 32'(fe * 4 + wr * 2));
                  // idle cycle after each access: holding registers must keep value (R11)
                  access(1'b0, 32'hFFFF_FFFF, 2'd2, 1'b1, 1'b0, 1'b1,
                         32'h1111_1111, 1'b1, 32'h2222_2222);
                end

    // R4 boundary addresses
    access(1'b1, 32'h7FFF_FFFC, 2'd2, 1'b0, 1'b0, 1'b1, 32'h100, 1'b0, 32'h0);
    access(1'b1, 32'h8000_0000, 2'd2, 1'b0, 1'b0, 1'b1, 32'h104, 1'b0, 32'h0);
    access(1'b1, 32'h8000_0000, 2'd2, 1'b1, 1'b0, 1'b0, 32'h108, 1'b0, 32'h0);
    // back-to-back faults
    access(1'b1, 32'h0000_0003, 2'd1, 1'b1, 1'b0, 1'b0, 32'h200, 1'b1, 32'h1FE);
    access(1'b1, 32'h0000_0005, 2'd0, 1'b0, 1'b1, 1'b0, 32'h204, 1'b0, 32'h0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule